// File: doc/BRIEF.md
# Two-Level Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short shift register of the outcomes of the most recently resolved branches, the global history. A single untagged table holds saturating counters. Each counter is found through an index made of a few low instruction-address bits, with the global history as the low part. The address bits choose a row, and the history chooses one counter inside that row. Because of this, the recent behaviour of other branches decides which counter predicts the current one.

The fetch side presents a PC on the lookup port. It gets back a taken or not-taken hint in the same cycle, together with the history value in use at that moment. That history value travels down the pipeline with the branch. When the branch resolves, the update port receives its PC, its real outcome and the history it carried. The block then trains the counter the prediction used and shifts the outcome into the global history. A misprediction costs nothing more than that retraining, because the hint carries no guarantee.

Top module: `corr_branch_predictor`

## Requirements
- R1: While reset is held and right after it is released, the global history reads zero. Every counter holds the weak not-taken value 2^(CTR_W-1)-1, so every lookup predicts not taken.
- R2: The lookup index is {pc[OFS_W+ROW_W-1:OFS_W], history}, with the history in the low HIST_W bits. PC bits below OFS_W have no effect on the prediction. With the defaults this is 16 rows of 4 counters, 64 counters in all.
- R3: A valid update with outcome taken increments the selected counter, saturating at 2^CTR_W-1.
- R4: A valid update with outcome not taken decrements the selected counter, saturating at 0.
- R5: The lookup output is 1 (taken) exactly when the indexed counter is at least 2^(CTR_W-1), and the output is combinational from the current lookup PC and history.
- R6: Each valid update shifts the history left by one and puts the new outcome in bit 0 (1 = taken). The oldest bit drops out.
- R7: The update trains the counter at {up_pc row bits, up_hist}, using the history that came with the update rather than the current global history.
- R8: When a lookup and an update address the same counter in one cycle, the lookup returns the value from before the update.
- R9: Entries carry no tags. Two PCs that agree in the row bits share counters and train each other.
- R10: When up_valid is low, neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC of the instruction being fetched |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| cur_hist | output | HIST_W | Global history in use now; carried with the branch |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_hist | input | HIST_W | History that was in use when the branch was predicted |

## Verification
A wrong counter value stays hidden until some lookup reaches that exact row and history pair. Even then it only shows when the fault moves the counter across the midpoint. For that reason the reference model compares the hint on every cycle, with lookups that often revisit recently trained entries. Saturation faults show only after a run of same-direction updates followed by a reversal. A history fault shows at cur_hist on the clock after the update, and it also misdirects every later lookup.

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  parameter int ROW_W  = 4,
  parameter int PC_W   = 32,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] cur_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken,
  input  logic [HIST_W-1:0] up_hist
);
  localparam int IDX_W = ROW_W + HIST_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_ZERO = '0;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W-1)) - 1);

  logic [CTR_W-1:0]  ctr_q [DEPTH];
  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [CTR_W-1:0]  up_cur, up_nxt;

  assign lk_idx   = {lk_pc[OFS_W +: ROW_W], hist_q};
  assign up_idx   = {up_pc[OFS_W +: ROW_W], up_hist};
  assign lk_taken = ctr_q[lk_idx][CTR_W-1];
  assign cur_hist = hist_q;
  assign up_cur   = ctr_q[up_idx];

  always_comb begin
    up_nxt = up_cur;
    if (up_taken && up_cur != CTR_MAX)       up_nxt = up_cur + 1'b1;
    else if (!up_taken && up_cur != CTR_ZERO) up_nxt = up_cur - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
      hist_q <= '0;
    end else if (up_valid) begin
      ctr_q[up_idx] <= up_nxt;
      hist_q        <= HIST_W'({hist_q, up_taken});
    end
  end
endmodule

// File: rtl/corr_bp_chk.sv
module corr_bp_chk #(
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  parameter int ROW_W  = 4,
  parameter int PC_W   = 32,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   lk_pc,
  input logic              lk_taken,
  input logic [HIST_W-1:0] cur_hist,
  input logic              up_valid,
  input logic [PC_W-1:0]   up_pc,
  input logic              up_taken,
  input logic [HIST_W-1:0] up_hist
);
  logic [ROW_W+HIST_W-1:0] a_lk, a_up;
  assign a_lk = {lk_pc[OFS_W +: ROW_W], cur_hist};
  assign a_up = {up_pc[OFS_W +: ROW_W], up_hist};

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> cur_hist == HIST_W'({$past(cur_hist), $past(up_taken)}));

  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(cur_hist));

  // R10
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> (!($stable(lk_pc) && $stable(cur_hist)) || $stable(lk_taken)));

  // R3
  taken_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && lk_taken && a_lk == a_up)
      |=> (a_lk != $past(a_up)) || lk_taken);
endmodule

bind corr_branch_predictor corr_bp_chk #(
  .HIST_W(HIST_W), .CTR_W(CTR_W), .ROW_W(ROW_W), .PC_W(PC_W), .OFS_W(OFS_W)
) u_chk (.*);

// File: tb/tb_corr_branch_predictor.sv
module tb_corr_branch_predictor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic [1:0]  cur_hist;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic [1:0]  up_hist = '0;

  int checks = 0;
  int errors = 0;
  int mctr[64];
  int mhist;

  corr_branch_predictor dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int midx(logic [31:0] pc, int h);
    return int'((pc >> 2) & 32'hF) * 4 + (h & 3);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    foreach (mctr[i]) mctr[i] = 1;
    mhist = 0;
  endtask

  // Called at a falling edge; drives, compares, then advances one clock.
  task automatic step(string req, logic [31:0] lpc, logic uv,
                      logic [31:0] upc, logic ut, int uh);
    int k;
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut; up_hist = 2'(uh);
    #1;
    check({req, " pred"}, int'(lk_taken), int'(mctr[midx(lpc, mhist)] >= 2));
    check("R6 hist", int'(cur_hist), mhist);
    @(posedge clk);
    if (uv) begin
      k = midx(upc, uh);
      if (ut && mctr[k] < 3) mctr[k]++;
      else if (!ut && mctr[k] > 0) mctr[k]--;
      mhist = ((mhist << 1) | int'(ut)) & 3;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: history clear and weak not-taken in reset
    #1 check("R1 hist in reset", int'(cur_hist), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 16; r++) begin
      lk_pc = 32'(r * 4); #1;
      check("R1 pred after reset", int'(lk_taken), 0);
      @(negedge clk);
    end
    // R1: one taken update flips a weak not-taken counter (history 0)
    step("R1", 32'h104, 1, 32'h104, 1, 0);
    step("R5", 32'h104, 0, 0, 0, 0);
    // R3: saturate entry row 1, history 3
    for (int i = 0; i < 5; i++) step("R3", 32'h104, 1, 32'h104, 1, 3);
    step("R3 sat", 32'h104, 0, 0, 0, 0);
    lk_pc = 32'h104; #1;
    check("R3 saturated taken", int'(lk_taken), 1);
    @(negedge clk);
    // R4: one not-taken after saturation stays taken, then more go to 0
    step("R4", 32'h104, 1, 32'h104, 0, 3);
    for (int i = 0; i < 6; i++) step("R4", 32'h104, 1, 32'h104, 0, 3);
    for (int i = 0; i < 2; i++) step("R4 sat", 32'h104, 1, 32'h104, 1, 3);
    // R2: byte offset bits ignored
    for (int o = 0; o < 4; o++) step("R2", 32'h104 + 32'(o), 0, 0, 0, 0);
    // R7: update history differs from current history
    for (int i = 0; i < 3; i++) step("R7", 32'h208, 1, 32'h208, 1, 2);
    for (int i = 0; i < 2; i++) step("R7", 32'h208, 1, 32'h300, 0, 0);
    step("R7", 32'h208, 0, 0, 0, 0);
    // R8: same-entry lookup and update in one cycle
    for (int i = 0; i < 4; i++) step("R8", 32'h30C, 1, 32'h30C, 1, mhist);
    // R9: aliasing PCs share counters
    for (int i = 0; i < 3; i++) step("R9", 32'h1104, 1, 32'h0104, 1, 3);
    step("R9", 32'h2104, 0, 0, 0, 0);
    // R10: idle cycles leave state untouched
    for (int i = 0; i < 8; i++) step("R10", 32'(i * 4), 0, 32'(i * 4), 1, i);
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, b;
      a = 32'($urandom_range(0, 7) * 4 + $urandom_range(0, 3));
      b = ($urandom_range(0, 3) == 0) ? a : 32'($urandom_range(0, 7) * 4 + 32'h1000);
      step("R5", a, 1'($urandom_range(0, 3) != 0), b,
           1'($urandom_range(0, 2) != 0),
           ($urandom_range(0, 1) == 0) ? mhist : int'($urandom_range(0, 3)));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule